// File: doc/BRIEF.md
# Instruction Memory Fill Controller

This block is a slave on a register bus of the Device Control Register (DCR) kind. Software uses it to load and inspect a processor's instruction-side on-chip memory, one 32-bit word at a time. It holds three registers: a location register, a fill register and a mode register. Software first writes a word address into the location register. It then writes the instruction word into the fill register, and that write stores the word into the memory.

The memory is split into two interleaved 32-bit banks, even and odd. The lowest word-address bit picks the bank, and the higher address bits pick the entry inside it. Both banks are modelled inside the block.

One bit of the mode register controls two things. It sets how the location register is aligned when read back. It also decides whether a fill-register read returns the last written value or the live memory word at the current location.

Bit numbers below count from the least significant bit (bit 0 = LSB). The address field sits in location-register bits [23:2]. Within that field, bit [2] selects the bank and bits [23:3] form the word address. The mode bit is mode-register bit [29]. Register numbers default to 0x040 (location), 0x041 (fill) and 0x042 (mode).

Top module: `imfc_top`

## Requirements
- R1: Synchronous reset clears the location, fill and mode registers to zero and holds `dcr_ack` low and `dcr_rdata` at zero.
- R2: A write strobe to a decoded register number is acknowledged for one cycle, one clock after the strobe. Every mode-register bit is stored and read back. Only write-data bits [23:2] are kept by the location register, and the fill register keeps all 32 bits.
- R3: A fill-register write stores the write data into the bank chosen by location bit [2] (0 = even, 1 = odd), at entry location[11:3]; the upper bits of the word address are not used. The location register does not change after a fill write.
- R4: With mode bit [29] = 0, a location read returns location bits [23:2] in read bits [31:10], with bits [9:0] zero.
- R5: With mode bit [29] = 1, a location read returns location bits [23:2] in read bits [23:2], with all other bits zero.
- R6: With mode bit [29] = 0, a fill read returns the last value written to the fill register and is acknowledged one clock after the strobe.
- R7: With mode bit [29] = 1, a fill read returns the memory word at the current location and is acknowledged two clocks after the strobe.
- R8: A strobe to a register number that is not decoded produces no acknowledge and changes no register.
- R9: `dcr_rdata` is zero in every cycle without an acknowledge, and also during a write acknowledge.
- R10: Strobes that arrive while a live-memory read is waiting for its acknowledge are ignored. When read and write strobes are raised together, the access is a write.
- R11: Reset leaves the contents of both memory banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dcr_rd | input | 1 | Read strobe, one-cycle pulse |
| dcr_wr | input | 1 | Write strobe, one-cycle pulse |
| dcr_num | input | 10 | Register number |
| dcr_wdata | input | 32 | Write data |
| dcr_rdata | output | 32 | Read data, valid with the acknowledge |
| dcr_ack | output | 1 | One-cycle access acknowledge |

## Verification
- **Bank select.** A wrong bank or entry index chosen at fill time stays hidden until the word is read back in live mode. That read then returns the other bank's word or stale data two clocks after its strobe. The bench therefore writes distinct words to the even and odd halves of one entry, and to entries that differ only in their upper address bits, then reads each one back.
- **Mode bit.** A stuck or misplaced mode bit shows up on the very next location read as a shifted field, and on fill reads as a latency of one instead of two.
- **Pending flag.** A pending flag that does not clear, or does not block, shows up as a missing acknowledge. It also shows up as a location register altered by a strobe that should have been dropped.

// File: rtl/imfc_pkg.sv
package imfc_pkg;
  localparam int DATA_W   = 32;
  localparam int LOC_W    = 22;   // address field width, bits [23:2]
  localparam int LOC_LSB  = 2;    // position of the bank-select bit
  localparam int MODE_BIT = 29;   // readback-mode bit of the mode register

  typedef enum logic [1:0] {SEL_NONE, SEL_LOC, SEL_FILL, SEL_MODE} reg_sel_e;

  // Location readback: aligned keeps the field in place, packed puts it at the top.
  function automatic logic [DATA_W-1:0] loc_readback(logic [LOC_W-1:0] loc,
                                                     logic aligned);
    logic [DATA_W-1:0] wide;
    wide = DATA_W'(loc);
    return aligned ? (wide << LOC_LSB) : (wide << (DATA_W - LOC_W));
  endfunction

  function automatic logic bank_of(logic [LOC_W-1:0] loc);
    return loc[0];
  endfunction
endpackage

// File: rtl/imfc_bank.sv
module imfc_bank #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // No reset on the array: contents survive a block reset.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/imfc_regs.sv
module imfc_regs
  import imfc_pkg::*;
#(
  parameter int NUM_W    = 10,
  parameter logic [NUM_W-1:0] LOC_NUM  = 10'h040,
  parameter logic [NUM_W-1:0] FILL_NUM = 10'h041,
  parameter logic [NUM_W-1:0] MODE_NUM = 10'h042
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dcr_rd,
  input  logic              dcr_wr,
  input  logic [NUM_W-1:0]  dcr_num,
  input  logic [DATA_W-1:0] dcr_wdata,
  output logic [LOC_W-1:0]  loc_q,
  output logic [DATA_W-1:0] fill_q,
  output logic [DATA_W-1:0] mode_q,
  output logic              hit,        // register number decoded
  output logic              accept,     // access taken this cycle
  output logic              is_write,
  output reg_sel_e          sel,
  output logic              fill_we,    // event: word committed to memory
  output logic              live_start, // event: live memory read launched
  output logic              pend_q      // live read waiting for acknowledge
);
  always_comb begin
    unique case (dcr_num)
      LOC_NUM:  sel = SEL_LOC;
      FILL_NUM: sel = SEL_FILL;
      MODE_NUM: sel = SEL_MODE;
      default:  sel = SEL_NONE;
    endcase
  end

  assign hit        = (sel != SEL_NONE);
  assign accept     = (dcr_rd | dcr_wr) & hit & ~pend_q;
  assign is_write   = dcr_wr;
  assign fill_we    = accept & is_write & (sel == SEL_FILL);
  assign live_start = accept & ~is_write & (sel == SEL_FILL) & mode_q[MODE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_q  <= '0;
      fill_q <= '0;
      mode_q <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= live_start;
      if (accept && is_write) begin
        case (sel)
          SEL_LOC:  loc_q  <= dcr_wdata[LOC_LSB +: LOC_W];
          SEL_FILL: fill_q <= dcr_wdata;
          SEL_MODE: mode_q <= dcr_wdata;
          default:  ;
        endcase
      end
    end
  end

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> ($stable(loc_q) && $stable(fill_q) && $stable(mode_q)));

  // R3
  no_autoinc_chk: assert property (@(posedge clk) disable iff (rst)
    fill_we |=> $stable(loc_q));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (loc_q == '0 && fill_q == '0 && mode_q == '0 && !pend_q));
endmodule

// File: rtl/imfc_top.sv
module imfc_top
  import imfc_pkg::*;
#(
  parameter int NUM_W      = 10,
  parameter int BANK_DEPTH = 512,
  parameter logic [NUM_W-1:0] LOC_NUM  = 10'h040,
  parameter logic [NUM_W-1:0] FILL_NUM = 10'h041,
  parameter logic [NUM_W-1:0] MODE_NUM = 10'h042
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dcr_rd,
  input  logic              dcr_wr,
  input  logic [NUM_W-1:0]  dcr_num,
  input  logic [DATA_W-1:0] dcr_wdata,
  output logic [DATA_W-1:0] dcr_rdata,
  output logic              dcr_ack
);
  localparam int IDX_W = $clog2(BANK_DEPTH);

  logic [LOC_W-1:0]  loc_q;
  logic [DATA_W-1:0] fill_q, mode_q;
  logic              hit, accept, is_write, fill_we, live_start, pend_q;
  reg_sel_e          sel;
  logic [IDX_W-1:0]  word_idx;
  logic              bank_sel, pend_bank_q;
  logic [DATA_W-1:0] bank_rdata [2];
  logic [DATA_W-1:0] quick_data;

  imfc_regs #(
    .NUM_W(NUM_W), .LOC_NUM(LOC_NUM), .FILL_NUM(FILL_NUM), .MODE_NUM(MODE_NUM)
  ) regs_i (
    .clk(clk), .rst(rst), .dcr_rd(dcr_rd), .dcr_wr(dcr_wr), .dcr_num(dcr_num),
    .dcr_wdata(dcr_wdata), .loc_q(loc_q), .fill_q(fill_q), .mode_q(mode_q),
    .hit(hit), .accept(accept), .is_write(is_write), .sel(sel),
    .fill_we(fill_we), .live_start(live_start), .pend_q(pend_q)
  );

  assign word_idx = loc_q[IDX_W:1];
  assign bank_sel = bank_of(loc_q);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    imfc_bank #(.WIDTH(DATA_W), .DEPTH(BANK_DEPTH)) bank_i (
      .clk(clk),
      .we(fill_we && (bank_sel == b[0])),
      .re(live_start && (bank_sel == b[0])),
      .addr(word_idx),
      .wdata(dcr_wdata),
      .rdata(bank_rdata[b])
    );
  end

  // Data for accesses answered in one cycle.
  always_comb begin
    quick_data = '0;
    if (!is_write) begin
      case (sel)
        SEL_LOC:  quick_data = loc_readback(loc_q, mode_q[MODE_BIT]);
        SEL_FILL: quick_data = fill_q;
        SEL_MODE: quick_data = mode_q;
        default:  quick_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcr_ack     <= 1'b0;
      dcr_rdata   <= '0;
      pend_bank_q <= 1'b0;
    end else begin
      dcr_ack   <= 1'b0;
      dcr_rdata <= '0;
      if (live_start) pend_bank_q <= bank_sel;
      if (pend_q) begin
        dcr_ack   <= 1'b1;
        dcr_rdata <= bank_rdata[pend_bank_q];
      end else if (accept && !live_start) begin
        dcr_ack   <= 1'b1;
        dcr_rdata <= quick_data;
      end
    end
  end

  // R2
  wr_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (dcr_wr && hit && !pend_q) |=> dcr_ack);

  // R7
  live_lat_chk: assert property (@(posedge clk) disable iff (rst)
    live_start |=> (!dcr_ack ##1 dcr_ack));

  // R8
  undec_noack_chk: assert property (@(posedge clk) disable iff (rst)
    ((dcr_rd || dcr_wr) && !hit && !pend_q) |=> !dcr_ack);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dcr_ack |-> (dcr_rdata == '0));

  // R1
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (!dcr_ack && dcr_rdata == '0));
endmodule

// File: tb/imfc_top_tb_top.sv
module imfc_top_tb_top;
  localparam logic [9:0] N_LOC  = 10'h040;
  localparam logic [9:0] N_FILL = 10'h041;
  localparam logic [9:0] N_MODE = 10'h042;
  localparam logic [31:0] MODE_ON = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dcr_rd = 1'b0, dcr_wr = 1'b0;
  logic [9:0]  dcr_num = '0;
  logic [31:0] dcr_wdata = '0;
  logic [31:0] dcr_rdata;
  logic        dcr_ack;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  imfc_top dut_i (
    .clk(clk), .rst(rst), .dcr_rd(dcr_rd), .dcr_wr(dcr_wr), .dcr_num(dcr_num),
    .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata), .dcr_ack(dcr_ack)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Launch one access, return the cycles to acknowledge (0 = none in 4) and data.
  task automatic access(logic wr, logic [9:0] num, logic [31:0] wd,
                        output int lat, output logic [31:0] rd);
    @(negedge clk);
    dcr_wr = wr; dcr_rd = ~wr; dcr_num = num; dcr_wdata = wd;
    lat = 0; rd = '0;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      dcr_wr = 1'b0; dcr_rd = 1'b0;
      if (dcr_ack) begin lat = c; rd = dcr_rdata; break; end
      check("R9 idle rdata", dcr_rdata, 32'h0);
    end
  endtask

  task automatic wr_reg(string req, logic [9:0] num, logic [31:0] wd);
    int lat; logic [31:0] d;
    access(1'b1, num, wd, lat, d);
    check({req, " write latency"}, 32'(lat), 32'd1);
    check("R9 write ack rdata", d, 32'h0);
  endtask

  task automatic rd_reg(string req, logic [9:0] num, int exp_lat, logic [31:0] exp);
    int lat; logic [31:0] d;
    access(1'b0, num, '0, lat, d);
    check({req, " read latency"}, 32'(lat), 32'(exp_lat));
    check({req, " read data"}, d, exp);
  endtask

  function automatic logic [21:0] fld(logic [31:0] w);
    return w[23:2];
  endfunction

  task automatic t_reset_state();
    check("R1 ack after reset", 32'(dcr_ack), 32'h0);
    check("R1 rdata after reset", dcr_rdata, 32'h0);
    rd_reg("R1 mode", N_MODE, 1, 32'h0);
    rd_reg("R1 loc", N_LOC, 1, 32'h0);
    rd_reg("R1 fill", N_FILL, 1, 32'h0);
  endtask

  task automatic t_loc_readback();
    logic [31:0] w = 32'hFFA5_C3F7;
    wr_reg("R2", N_MODE, 32'h0000_0000);
    wr_reg("R2", N_LOC, w);
    rd_reg("R4 packed", N_LOC, 1, {fld(w), 10'b0});
    wr_reg("R2", N_MODE, MODE_ON | 32'h0000_0011);
    rd_reg("R2 mode store", N_MODE, 1, MODE_ON | 32'h0000_0011);
    rd_reg("R5 aligned", N_LOC, 1, {8'h00, fld(w), 2'b00});
  endtask

  task automatic t_fill_banks();
    // entry 5 even/odd, entry 5 aliased via upper bits, entry 511 odd
    wr_reg("R2", N_MODE, 32'h0);
    wr_reg("R3", N_LOC, 32'h0000_0028);  // idx 5, even
    wr_reg("R3", N_FILL, 32'h1111_AAAA);
    rd_reg("R3 no autoinc", N_LOC, 1, {22'h00000A, 10'b0});
    wr_reg("R3", N_LOC, 32'h0000_002C);  // idx 5, odd
    wr_reg("R3", N_FILL, 32'h2222_BBBB);
    wr_reg("R3", N_LOC, 32'h0000_0FFC);  // idx 511, odd
    wr_reg("R3", N_FILL, 32'h3333_CCCC);
    rd_reg("R6 last fill", N_FILL, 1, 32'h3333_CCCC);
    wr_reg("R2", N_MODE, MODE_ON);
    wr_reg("R3", N_LOC, 32'h0000_0028);
    rd_reg("R7 even idx5", N_FILL, 2, 32'h1111_AAAA);
    wr_reg("R3", N_LOC, 32'h0000_002C);
    rd_reg("R7 odd idx5", N_FILL, 2, 32'h2222_BBBB);
    wr_reg("R3", N_LOC, 32'h00F0_102C);  // upper bits ignored -> idx 5 odd
    rd_reg("R3 upper bits unused", N_FILL, 2, 32'h2222_BBBB);
    wr_reg("R3", N_LOC, 32'h0000_0FFC);
    rd_reg("R7 odd idx511", N_FILL, 2, 32'h3333_CCCC);
  endtask

  task automatic t_undecoded();
    int lat; logic [31:0] d;
    wr_reg("R8", N_MODE, 32'h0);
    wr_reg("R8", N_LOC, 32'h0000_0104);
    access(1'b1, 10'h043, 32'hFFFF_FFFF, lat, d);
    check("R8 write no ack", 32'(lat), 32'd0);
    access(1'b0, 10'h000, '0, lat, d);
    check("R8 read no ack", 32'(lat), 32'd0);
    rd_reg("R8 loc unchanged", N_LOC, 1, {22'h000041, 10'b0});
    rd_reg("R8 mode unchanged", N_MODE, 1, 32'h0);
  endtask

  task automatic t_busy_and_both();
    wr_reg("R10", N_MODE, MODE_ON);
    wr_reg("R10", N_LOC, 32'h0000_0028);
    @(negedge clk);
    dcr_rd = 1'b1; dcr_num = N_FILL;
    @(negedge clk);
    dcr_rd = 1'b0; dcr_wr = 1'b1; dcr_num = N_LOC; dcr_wdata = 32'h0000_0FFC;
    @(negedge clk);
    dcr_wr = 1'b0;
    check("R10 live ack", 32'(dcr_ack), 32'h1);
    check("R10 live data", dcr_rdata, 32'h1111_AAAA);
    @(negedge clk);
    check("R10 single ack", 32'(dcr_ack), 32'h0);
    rd_reg("R10 loc kept", N_LOC, 1, {8'h00, 22'h00000A, 2'b00});
    @(negedge clk);
    dcr_rd = 1'b1; dcr_wr = 1'b1; dcr_num = N_LOC; dcr_wdata = 32'h0000_0044;
    @(negedge clk);
    dcr_rd = 1'b0; dcr_wr = 1'b0;
    check("R10 both ack", 32'(dcr_ack), 32'h1);
    check("R10 both write rdata", dcr_rdata, 32'h0);
    rd_reg("R10 both wrote", N_LOC, 1, 32'h0000_0044);
  endtask

  task automatic t_reset_keeps_mem();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R1 ack in reset", 32'(dcr_ack), 32'h0);
    rd_reg("R1 loc cleared", N_LOC, 1, 32'h0);
    rd_reg("R1 fill cleared", N_FILL, 1, 32'h0);
    wr_reg("R11", N_MODE, MODE_ON);
    wr_reg("R11", N_LOC, 32'h0000_002C);
    rd_reg("R11 odd idx5 kept", N_FILL, 2, 32'h2222_BBBB);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_loc_readback();
    t_fill_banks();
    t_undecoded();
    t_busy_and_both();
    t_reset_keeps_mem();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule